// File: doc/BRIEF.md
# Operand Stream Address Generator

This block generates memory addresses for an operand stream and formats the words read back, so a datapath can take its operands straight from memory with no load instructions, no pointer arithmetic and no unpacking steps. Software first loads a byte-address pointer and a small bank of signed stride modifiers. After that, each access request names one modifier. The block then issues the current pointer as the memory address and moves the pointer by that modifier in the same cycle.

Two-dimensional traversal uses two or more modifiers. One holds a short step between neighbouring elements in a row. Another holds the jump from the last element of a row to the first element of the next row. On the read side, each access carries a conversion mode. The mode either passes the 32-bit word through, widens two packed signed bytes into two 16-bit lanes, copies the low halfword into both lanes, or sign-extends the low byte and copies it into both lanes. The formatted operand appears one cycle after its address, which matches a synchronous memory.

Top module: `opnd_agu`

## Requirements
- R1: After reset, the pointer and all modifiers are zero, `opnd_valid_o` is low, and `mem_req_o` stays low until a request is made.
- R2: An access is accepted when `acc_req_i` is high and neither setup write is high. In that cycle `mem_req_o` is high and `mem_addr_o` equals the pointer value held before the update (post-modify addressing). With no accepted access and no pointer write, the pointer holds its value.
- R3: On an accepted access, the pointer becomes pointer plus the modifier selected by `acc_mod_sel_i`. The modifier is read as a signed 16-bit value and the sum wraps modulo 2^16.
- R4: Setup writes take priority over an access in the same cycle. Such an access is dropped: `mem_req_o` stays low, no operand follows, and the pointer takes the written value (for `cfg_ptr_we_i`) or is left unchanged (for `cfg_mod_we_i` alone).
- R5: `opnd_valid_o` is high exactly in the cycle after an accepted access. `opnd_o` is then formed from `mem_rdata_i` in that cycle, using the mode given with the access.
- R6: Mode 2'b00 passes the word through: `opnd_o` = `mem_rdata_i`.
- R7: Mode 2'b01 widens bytes: `opnd_o[15:0]` is the sign extension of `mem_rdata_i[7:0]` and `opnd_o[31:16]` is the sign extension of `mem_rdata_i[15:8]`.
- R8: Mode 2'b10 replicates the halfword: both `opnd_o[31:16]` and `opnd_o[15:0]` equal `mem_rdata_i[15:0]`.
- R9: Mode 2'b11 replicates the byte: both lanes equal the sign extension of `mem_rdata_i[7:0]`.
- R10: Each modifier index holds its own value, written by `cfg_mod_we_i` at `cfg_mod_idx_i`. Alternating selections walk a 2D pattern: small steps within a row, then a row jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_ptr_we_i | input | 1 | Pointer setup write |
| cfg_ptr_i | input | ADDR_W | Pointer value to load |
| cfg_mod_we_i | input | 1 | Modifier setup write |
| cfg_mod_idx_i | input | SEL_W | Modifier index to write |
| cfg_mod_i | input | MOD_W | Signed modifier value |
| acc_req_i | input | 1 | Access request |
| acc_mod_sel_i | input | SEL_W | Modifier applied after this access |
| acc_mode_i | input | 2 | Conversion mode of this access |
| mem_req_o | output | 1 | Memory access issued |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_rdata_i | input | 32 | Read data, one cycle after the address |
| opnd_valid_o | output | 1 | Formatted operand valid |
| opnd_o | output | 32 | Formatted operand, two 16-bit lanes |

## Verification
The bench builds the block with its defaults: a 16-bit pointer, 16-bit modifiers and four modifiers. With these values, both wrap directions of the pointer can be reached in a few accesses, and so can a negative stride and the largest positive stride. Four modifiers are enough for a three-column row walk that uses separate in-row and next-row strides. All four conversion modes are applied to memory words whose bytes have their top bit set and clear. Setup writes are placed in the same cycle as requests to exercise the priority rule.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    CONV_PASS  = 2'b00,
    CONV_SX8   = 2'b01,
    CONV_REP16 = 2'b10,
    CONV_REP8  = 2'b11
  } conv_mode_e;
endpackage

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
  parameter int ADDR_W   = 16,
  parameter int MOD_W    = 16,
  parameter int NUM_MODS = 4,
  localparam int SEL_W   = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_we_i,
  input  logic [ADDR_W-1:0] ptr_wdata_i,
  input  logic              mod_we_i,
  input  logic [SEL_W-1:0]  mod_idx_i,
  input  logic [MOD_W-1:0]  mod_wdata_i,
  input  logic              step_i,
  input  logic [SEL_W-1:0]  step_sel_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [MOD_W-1:0]  mod_q [NUM_MODS];
  logic [MOD_W-1:0]  step_mod;

  for (genvar g = 0; g < NUM_MODS; g++) begin : g_mod
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mod_q[g] <= '0;
      else if (mod_we_i && mod_idx_i == SEL_W'(g))    mod_q[g] <= mod_wdata_i;
    end
  end

  assign step_mod = mod_q[step_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (ptr_we_i) ptr_q <= ptr_wdata_i;
    else if (step_i)   ptr_q <= ptr_q + ADDR_W'($signed(step_mod));
  end

  assign ptr_o = ptr_q;

  // R2
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !ptr_we_i) |=> $stable(ptr_q));
endmodule

// File: rtl/agu_lane_fmt.sv
module agu_lane_fmt
  import agu_pkg::*;
(
  input  conv_mode_e  mode_i,
  input  logic [31:0] word_i,
  output logic [31:0] opnd_o
);
  logic [15:0] sx_lo, sx_hi;

  assign sx_lo = {{8{word_i[7]}},  word_i[7:0]};
  assign sx_hi = {{8{word_i[15]}}, word_i[15:8]};

  always_comb begin
    unique case (mode_i)
      CONV_PASS:  opnd_o = word_i;
      CONV_SX8:   opnd_o = {sx_hi, sx_lo};
      CONV_REP16: opnd_o = {word_i[15:0], word_i[15:0]};
      CONV_REP8:  opnd_o = {sx_lo, sx_lo};
      default:    opnd_o = word_i;
    endcase
  end
endmodule

// File: rtl/opnd_agu.sv
module opnd_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int MOD_W    = 16,
  parameter int NUM_MODS = 4,
  localparam int SEL_W   = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_ptr_we_i,
  input  logic [ADDR_W-1:0] cfg_ptr_i,
  input  logic              cfg_mod_we_i,
  input  logic [SEL_W-1:0]  cfg_mod_idx_i,
  input  logic [MOD_W-1:0]  cfg_mod_i,
  input  logic              acc_req_i,
  input  logic [SEL_W-1:0]  acc_mod_sel_i,
  input  logic [1:0]        acc_mode_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              opnd_valid_o,
  output logic [31:0]       opnd_o
);
  logic       fire;
  logic       valid_q;
  conv_mode_e mode_q;

  // setup traffic wins; a colliding access is dropped
  assign fire = acc_req_i && !cfg_ptr_we_i && !cfg_mod_we_i;

  agu_ptr_file #(.ADDR_W(ADDR_W), .MOD_W(MOD_W), .NUM_MODS(NUM_MODS)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ptr_we_i    (cfg_ptr_we_i),
    .ptr_wdata_i (cfg_ptr_i),
    .mod_we_i    (cfg_mod_we_i),
    .mod_idx_i   (cfg_mod_idx_i),
    .mod_wdata_i (cfg_mod_i),
    .step_i      (fire),
    .step_sel_i  (acc_mod_sel_i),
    .ptr_o       (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mode_q  <= CONV_PASS;
    end else begin
      valid_q <= fire;
      if (fire) mode_q <= conv_mode_e'(acc_mode_i);
    end
  end

  agu_lane_fmt u_fmt (
    .mode_i (mode_q),
    .word_i (mem_rdata_i),
    .opnd_o (opnd_o)
  );

  assign mem_req_o    = fire;
  assign opnd_valid_o = valid_q;

  // R4
  setup_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ptr_we_i || cfg_mod_we_i) |-> !mem_req_o);
  // R5
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> opnd_valid_o);
  // R5
  no_stray_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o |=> !opnd_valid_o);
  // R8
  rep16_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_valid_o && mode_q == CONV_REP16) |-> opnd_o[31:16] == opnd_o[15:0]);
  // R7
  sx8_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_valid_o && mode_q == CONV_SX8) |-> opnd_o[15:8] == {8{opnd_o[7]}});
endmodule

// File: tb/tb_opnd_agu.sv
module tb_opnd_agu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_ptr_we_i = 0;
  logic [15:0] cfg_ptr_i = 0;
  logic        cfg_mod_we_i = 0;
  logic [1:0]  cfg_mod_idx_i = 0;
  logic [15:0] cfg_mod_i = 0;
  logic        acc_req_i = 0;
  logic [1:0]  acc_mod_sel_i = 0;
  logic [1:0]  acc_mode_i = 0;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic [31:0] mem_rdata_i = 0;
  logic        opnd_valid_o;
  logic [31:0] opnd_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  int          m_ptr;
  int          m_mod [4];
  bit          pend_v;
  int          pend_addr;
  int          pend_mode;

  always #10 clk_i = ~clk_i;

  opnd_agu dut (.*);

  function automatic logic [31:0] mem_word(int a);
    logic [15:0] x;
    x = 16'(a);
    return {x ^ 16'hA5C3, ~x + 16'h0081};
  endfunction

  function automatic int sx8(int b);
    return (b >= 128) ? b - 256 : b;
  endfunction

  function automatic logic [31:0] model_fmt(logic [31:0] w, int mode);
    int b0, b1, h;
    b0 = sx8(int'(w[7:0]));
    b1 = sx8(int'(w[15:8]));
    h  = int'(w[15:0]);
    case (mode)
      0: return w;
      1: return {16'(b1), 16'(b0)};
      2: return {16'(h), 16'(h)};
      default: return {16'(b0), 16'(b0)};
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(bit pw, int pv, bit mw, int mi, int mv,
                      bit rq, int sel, int mode, string tag);
    bit acc;
    @(negedge clk_i);
    cfg_ptr_we_i = pw; cfg_ptr_i = 16'(pv);
    cfg_mod_we_i = mw; cfg_mod_idx_i = 2'(mi); cfg_mod_i = 16'(mv);
    acc_req_i = rq; acc_mod_sel_i = 2'(sel); acc_mode_i = 2'(mode);
    mem_rdata_i = pend_v ? mem_word(pend_addr) : 32'hDEAD_BEEF;
    #5;
    acc = rq && !pw && !mw;
    chk({tag, " R2/R4 mem_req"}, 32'(mem_req_o), 32'(acc));
    if (acc) chk({tag, " R2/R3 addr"}, 32'(mem_addr_o), 32'(m_ptr));
    chk({tag, " R5 valid"}, 32'(opnd_valid_o), 32'(pend_v));
    if (pend_v) begin
      case (pend_mode)
        0: chk({tag, " R6 pass"},   opnd_o, model_fmt(mem_word(pend_addr), 0));
        1: chk({tag, " R7 sx8"},    opnd_o, model_fmt(mem_word(pend_addr), 1));
        2: chk({tag, " R8 rep16"},  opnd_o, model_fmt(mem_word(pend_addr), 2));
        default: chk({tag, " R9 rep8"}, opnd_o, model_fmt(mem_word(pend_addr), 3));
      endcase
    end
    pend_v = acc; pend_addr = m_ptr; pend_mode = mode;
    if (pw) m_ptr = pv & 16'hFFFF;
    if (mw) m_mod[mi] = mv & 16'hFFFF;
    if (acc) m_ptr = (m_ptr + sx16(m_mod[sel])) & 16'hFFFF;
  endtask

  function automatic int sx16(int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_ptr = 0; pend_v = 0; pend_addr = 0; pend_mode = 0;
    for (int i = 0; i < 4; i++) m_mod[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state, zero modifiers leave pointer at 0
    idle("R1");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R1 zero ptr");
    step(0, 0, 0, 0, 0, 1, 3, 0, "R1 zero mod");
    idle("R1");
    // R10 setup: in-row +2, row jump +12, negative -4, max +0x7FFF
    step(0, 0, 1, 0, 2, 0, 0, 0, "R10 cfg");
    step(0, 0, 1, 1, 12, 0, 0, 0, "R10 cfg");
    step(0, 0, 1, 2, 16'hFFFC, 0, 0, 0, "R10 cfg");
    step(0, 0, 1, 3, 16'h7FFF, 0, 0, 0, "R10 cfg");
    step(1, 16'h0100, 0, 0, 0, 0, 0, 0, "R2 ptr load");
    // R10: two rows of three, varying modes
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 3; c++)
        step(0, 0, 0, 0, 0, 1, (c == 2) ? 1 : 0, (r * 3 + c) % 4, "R10 walk");
    idle("R2 hold");
    idle("R2 hold");
    // R3: negative stride and wrap below zero
    step(1, 16'h0002, 0, 0, 0, 0, 0, 0, "R3 load");
    step(0, 0, 0, 0, 0, 1, 2, 1, "R3 neg");
    step(0, 0, 0, 0, 0, 1, 2, 3, "R3 wrap down");
    // R3: wrap above 0xFFFF
    step(1, 16'hFFFE, 0, 0, 0, 0, 0, 0, "R3 load");
    step(0, 0, 0, 0, 0, 1, 0, 2, "R3 wrap up");
    step(0, 0, 0, 0, 0, 1, 3, 0, "R3 max");
    step(0, 0, 0, 0, 0, 1, 3, 1, "R3 max2");
    // R4: collision with pointer write and with modifier write
    step(1, 16'h4000, 0, 0, 0, 1, 0, 2, "R4 ptr wins");
    step(0, 0, 1, 0, 6, 1, 0, 1, "R4 mod wins");
    step(0, 0, 0, 0, 0, 1, 0, 3, "R4 after");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R4 after");
    idle("R5 tail");
    // all modes back-to-back with sign variety
    step(1, 16'h0080, 0, 0, 0, 0, 0, 0, "R6 load");
    for (int k = 0; k < 12; k++)
      step(0, 0, 0, 0, 0, 1, k % 3, k % 4, "R6-9 mix");
    idle("R5 tail");
    idle("R5 tail");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule